// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the program counter of a processor whose opcodes are 16 bits wide. The opcodes sit in a byte memory with a 12-bit address space. The block produces the two byte addresses of each instruction fetch: the high byte at the counter and the low byte one above it. Every change of control flow goes through it: plain advance, conditional skip, absolute jump, jump offset by register 0, subroutine call and subroutine return. A return-address stack sits inside the block. Decode, the ALU and the memory array are outside it.

Control commands arrive on a valid/ready port. A command transfers on any clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays high while no fault is recorded. Once a fault is recorded, `cmd_ready` falls and stays low until reset. The upstream decoder holds its command and operands stable until the transfer happens. A command offered while `cmd_ready` is low has no effect.

The data-write watch pins (`dwr_en`, `dwr_addr`) are plain status inputs without a handshake. Every fault flag is sticky, and a fault freezes the counter and the stack until reset.

Top module: `pcseq_top`

## Requirements
- R1: While reset is held and after it is released, `fetch_hi_addr` is 0x200, `depth` is 0, all fault flags are 0 and `cmd_ready` is 1.
- R2: `fetch_lo_addr` always equals `fetch_hi_addr` + 1, modulo 4096.
- R3: An accepted command with `cmd_op` = 0 (advance) moves the counter up by 2. The reserved codes 6 and 7 behave the same way.
- R4: An accepted `cmd_op` = 1 (skip) moves the counter up by 4 when `skip_hit` is 1 and by 2 when it is 0.
- R5: An accepted `cmd_op` = 2 (jump) loads `target` into the counter.
- R6: An accepted `cmd_op` = 3 (indexed jump) loads `target` + `reg0` into the counter, modulo 4096.
- R7: An accepted `cmd_op` = 4 (call) with fewer than 15 entries held does three things. It stores the current counter value on the stack, raises `depth` by 1 and loads `target` into the counter.
- R8: An accepted `cmd_op` = 5 (return) with a non-empty stack removes the newest entry (last in, first out), lowers `depth` by 1 and loads the counter with that entry + 2.
- R9: A call accepted with 15 entries already held sets `fault_ovf`. It stores nothing, and `depth` stays at 15 and the counter is unchanged.
- R10: A return accepted with an empty stack sets `fault_unf`, and the counter and `depth` are unchanged.
- R11: `dwr_en` = 1 with `dwr_addr` below 0x200 sets `fault_prot` on the next edge. A write at 0x200 or above sets no flag.
- R12: Each fault flag is sticky until reset, and `fault_any` is their OR. While `fault_any` is 1, `cmd_ready` is 0, commands are ignored, and the counter and `depth` hold.
- R13: With no accepted command, the counter and `depth` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A control command is offered |
| cmd_ready | output | 1 | The block accepts commands (no fault recorded) |
| cmd_op | input | 3 | Command code: 0 advance, 1 skip, 2 jump, 3 indexed jump, 4 call, 5 return, 6/7 advance |
| skip_hit | input | 1 | Skip condition result for cmd_op 1 |
| target | input | 12 | Target address for jump, indexed jump and call |
| reg0 | input | 8 | Register 0 value for the indexed jump |
| dwr_en | input | 1 | A data write is taking place this cycle |
| dwr_addr | input | 12 | Address of that data write |
| fetch_hi_addr | output | 12 | Address of the opcode high byte (the counter) |
| fetch_lo_addr | output | 12 | Address of the opcode low byte |
| depth | output | 5 | Number of entries held on the return stack |
| fault_any | output | 1 | OR of all fault flags |
| fault_ovf | output | 1 | Sticky stack overflow fault |
| fault_unf | output | 1 | Sticky stack underflow fault |
| fault_prot | output | 1 | Sticky low-memory write fault |

## Verification
A long random phase mixes all eight command codes with random targets, register values, skip results and gaps in `cmd_valid`. It keeps calls and returns inside the legal depth range, so that arithmetic errors in the next-address paths can be told apart from fault handling. Deep call chains that unwind in order show whether the stack is last in, first out and whether a return adds the instruction step.

Directed cases then push exactly to the limit of 15 and one past it. They pop an empty stack and write just below and exactly at the protected boundary. They also offer commands after a fault. Together these separate off-by-one errors in the depth limit and the address compare from flags that fail to stick or a counter that keeps moving after a fault.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADV     = 3'd0,
    OP_SKIP    = 3'd1,
    OP_JUMP    = 3'd2,
    OP_JUMP_R0 = 3'd3,
    OP_CALL    = 3'd4,
    OP_RET     = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 8,
  parameter int STEP   = 2
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] pc,
  input  logic              skip_hit,
  input  logic [ADDR_W-1:0] target,
  input  logic [REG_W-1:0]  reg0,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] pc_next
);
  localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(STEP);
  localparam logic [ADDR_W-1:0] DSTEP_V = ADDR_W'(2 * STEP);

  logic [ADDR_W-1:0] reg0_ext;
  assign reg0_ext = ADDR_W'(reg0);

  always_comb begin
    case (op)
      OP_SKIP:    pc_next = pc + (skip_hit ? DSTEP_V : STEP_V);
      OP_JUMP:    pc_next = target;
      OP_JUMP_R0: pc_next = target + reg0_ext;
      OP_CALL:    pc_next = target;
      OP_RET:     pc_next = ret_addr + STEP_V;
      default:    pc_next = pc + STEP_V;
    endcase
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  parameter int LIMIT  = 15,
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] dout,
  output logic [DW-1:0]     depth,
  output logic              full,
  output logic              empty
);
  logic [ADDR_W-1:0] slot [DEPTH];
  logic [DW-1:0]     cnt;
  logic [DW-1:0]     top_idx;
  logic              do_push;
  logic              do_pop;

  assign full    = (cnt >= DW'(LIMIT));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign top_idx = cnt - 1'b1;
  assign depth   = cnt;
  assign dout    = empty ? '0 : slot[top_idx[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (do_push) cnt <= cnt + 1'b1;
    else if (do_pop) cnt <= cnt - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (cnt[IW-1:0] == IW'(g))) slot[g] <= din;
    end
  end
endmodule

// File: rtl/pcseq_fault.sv
module pcseq_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_ev,
  input  logic unf_ev,
  input  logic prot_ev,
  output logic fault_ovf,
  output logic fault_unf,
  output logic fault_prot,
  output logic fault_any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_ovf  <= 1'b0;
      fault_unf  <= 1'b0;
      fault_prot <= 1'b0;
    end else begin
      if (ovf_ev)  fault_ovf  <= 1'b1;
      if (unf_ev)  fault_unf  <= 1'b1;
      if (prot_ev) fault_prot <= 1'b1;
    end
  end

  assign fault_any = fault_ovf | fault_unf | fault_prot;
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int REG_W       = 8,
  parameter int STACK_DEPTH = 16,
  parameter int STACK_LIMIT = 15,
  parameter int RESET_PC    = 'h200,
  parameter int PROT_LIMIT  = 512,
  parameter int INSTR_BYTES = 2,
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              skip_hit,
  input  logic [ADDR_W-1:0] target,
  input  logic [REG_W-1:0]  reg0,
  input  logic              dwr_en,
  input  logic [ADDR_W-1:0] dwr_addr,
  output logic [ADDR_W-1:0] fetch_hi_addr,
  output logic [ADDR_W-1:0] fetch_lo_addr,
  output logic [DEPTH_W-1:0] depth,
  output logic              fault_any,
  output logic              fault_ovf,
  output logic              fault_unf,
  output logic              fault_prot
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_next;
  logic [ADDR_W-1:0] stk_top;
  logic              stk_full;
  logic              stk_empty;
  logic              accept;
  logic              is_call;
  logic              is_ret;
  logic              ovf_ev;
  logic              unf_ev;
  logic              prot_ev;

  assign cmd_ready = !fault_any;
  assign accept    = cmd_valid && cmd_ready;
  assign is_call   = accept && (cmd_op == OP_CALL);
  assign is_ret    = accept && (cmd_op == OP_RET);
  assign ovf_ev    = is_call && stk_full;
  assign unf_ev    = is_ret && stk_empty;
  assign prot_ev   = dwr_en && (dwr_addr < ADDR_W'(PROT_LIMIT));

  pcseq_next #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .STEP   (INSTR_BYTES)
  ) u_next (
    .op       (cmd_op),
    .pc       (pc_q),
    .skip_hit (skip_hit),
    .target   (target),
    .reg0     (reg0),
    .ret_addr (stk_top),
    .pc_next  (pc_next)
  );

  pcseq_stack #(
    .ADDR_W (ADDR_W),
    .DEPTH  (STACK_DEPTH),
    .LIMIT  (STACK_LIMIT)
  ) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (is_call),
    .pop   (is_ret),
    .din   (pc_q),
    .dout  (stk_top),
    .depth (depth),
    .full  (stk_full),
    .empty (stk_empty)
  );

  pcseq_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_ev     (ovf_ev),
    .unf_ev     (unf_ev),
    .prot_ev    (prot_ev),
    .fault_ovf  (fault_ovf),
    .fault_unf  (fault_unf),
    .fault_prot (fault_prot),
    .fault_any  (fault_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= ADDR_W'(RESET_PC);
    else if (accept && !ovf_ev && !unf_ev) pc_q <= pc_next;
  end

  assign fetch_hi_addr = pc_q;
  assign fetch_lo_addr = pc_q + 1'b1;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int ADDR_W      = 12,
  parameter int DEPTH_W     = 5,
  parameter int STACK_LIMIT = 15,
  parameter int PROT_LIMIT  = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] target,
  input logic              dwr_en,
  input logic [ADDR_W-1:0] dwr_addr,
  input logic [ADDR_W-1:0] fetch_hi_addr,
  input logic [DEPTH_W-1:0] depth,
  input logic              fault_any,
  input logic              fault_ovf,
  input logic              fault_unf,
  input logic              fault_prot
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd2) |=> fetch_hi_addr == $past(target));

  p_call_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd4 && depth < DEPTH_W'(STACK_LIMIT))
      |=> (depth == $past(depth) + 1'b1) && (fetch_hi_addr == $past(target)));

  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH_W'(STACK_LIMIT));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd4 && depth == DEPTH_W'(STACK_LIMIT))
      |=> fault_ovf && $stable(fetch_hi_addr) && $stable(depth));

  p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5 && depth == '0) |=> fault_unf && $stable(fetch_hi_addr));

  p_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_en && dwr_addr < ADDR_W'(PROT_LIMIT)) |=> fault_prot);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> fault_any);

  p_ready_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |-> !cmd_ready);

  p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(fetch_hi_addr) && $stable(depth));
endmodule

bind pcseq_top pcseq_chk #(
  .ADDR_W      (ADDR_W),
  .DEPTH_W     (DEPTH_W),
  .STACK_LIMIT (STACK_LIMIT),
  .PROT_LIMIT  (PROT_LIMIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_op        (cmd_op),
  .target        (target),
  .dwr_en        (dwr_en),
  .dwr_addr      (dwr_addr),
  .fetch_hi_addr (fetch_hi_addr),
  .depth         (depth),
  .fault_any     (fault_any),
  .fault_ovf     (fault_ovf),
  .fault_unf     (fault_unf),
  .fault_prot    (fault_prot)
);

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic        skip_hit = 1'b0;
  logic [11:0] target = '0;
  logic [7:0]  reg0 = '0;
  logic        dwr_en = 1'b0;
  logic [11:0] dwr_addr = '0;
  logic [11:0] fetch_hi_addr;
  logic [11:0] fetch_lo_addr;
  logic [4:0]  depth;
  logic        fault_any, fault_ovf, fault_unf, fault_prot;

  always #10 clk = ~clk;

  pcseq_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .skip_hit(skip_hit), .target(target), .reg0(reg0),
    .dwr_en(dwr_en), .dwr_addr(dwr_addr), .fetch_hi_addr(fetch_hi_addr),
    .fetch_lo_addr(fetch_lo_addr), .depth(depth), .fault_any(fault_any),
    .fault_ovf(fault_ovf), .fault_unf(fault_unf), .fault_prot(fault_prot)
  );

  int checks = 0;
  int errors = 0;
  logic [11:0] m_pc;
  logic [11:0] m_stk [16];
  int m_depth;
  bit m_ovf, m_unf, m_prot;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [11:0] lo_exp;
    lo_exp = 12'(m_pc + 12'd1);
    chk(fetch_hi_addr == m_pc, tag, int'(fetch_hi_addr), int'(m_pc));
    chk(fetch_lo_addr == lo_exp, "R2 low byte address", int'(fetch_lo_addr), int'(lo_exp));
    chk(int'(depth) == m_depth, {tag, " depth"}, int'(depth), m_depth);
    chk({fault_ovf, fault_unf, fault_prot} == {m_ovf, m_unf, m_prot}, "R12 fault flags",
        int'({fault_ovf, fault_unf, fault_prot}), int'({m_ovf, m_unf, m_prot}));
    chk(fault_any == (m_ovf | m_unf | m_prot) && cmd_ready == !(m_ovf | m_unf | m_prot),
        "R12 ready/any", int'({fault_any, cmd_ready}), int'({m_ovf | m_unf | m_prot, !(m_ovf | m_unf | m_prot)}));
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R4 skip";
      3'd2: return "R5 jump";
      3'd3: return "R6 indexed jump";
      3'd4: return "R7 call";
      3'd5: return "R8 return";
      default: return "R3 advance";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; dwr_en = 1'b0;
    m_pc = 12'h200; m_depth = 0; m_ovf = 0; m_unf = 0; m_prot = 0;
    repeat (2) @(posedge clk);
    #5 compare("R1 reset held");
    @(negedge clk);
    rst_n = 1'b1;
    #1 compare("R1 after reset");
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic sk,
                      input logic [11:0] tg, input logic [7:0] r0,
                      input logic we, input logic [11:0] wa, input string tag);
    bit acc;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; skip_hit = sk; target = tg; reg0 = r0;
    dwr_en = we; dwr_addr = wa;
    @(posedge clk);
    acc = v && !(m_ovf | m_unf | m_prot);
    if (acc) begin
      case (op)
        3'd1: m_pc = 12'(m_pc + (sk ? 12'd4 : 12'd2));
        3'd2: m_pc = tg;
        3'd3: m_pc = 12'(tg + {4'd0, r0});
        3'd4: if (m_depth == 15) m_ovf = 1;
              else begin m_stk[m_depth] = m_pc; m_depth++; m_pc = tg; end
        3'd5: if (m_depth == 0) m_unf = 1;
              else begin m_depth--; m_pc = 12'(m_stk[m_depth] + 12'd2); end
        default: m_pc = 12'(m_pc + 12'd2);
      endcase
    end
    if (we && wa < 12'h200) m_prot = 1;
    #5 compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R3, R4: directed advance and skip patterns, reserved codes
    step(1, 3'd0, 0, 12'h0, 8'h0, 0, 12'h0, "R3 advance");
    step(1, 3'd6, 0, 12'h0, 8'h0, 0, 12'h0, "R3 reserved code 6");
    step(1, 3'd7, 1, 12'h0, 8'h0, 0, 12'h0, "R3 reserved code 7");
    step(1, 3'd1, 1, 12'h0, 8'h0, 0, 12'h0, "R4 skip taken");
    step(1, 3'd1, 0, 12'h0, 8'h0, 0, 12'h0, "R4 skip not taken");
    // R6 wrap, R13 idle
    step(1, 3'd3, 0, 12'hFF0, 8'h20, 0, 12'h0, "R6 indexed jump wrap");
    step(0, 3'd2, 0, 12'h123, 8'h0, 0, 12'h300, "R13 idle hold");
    // R2 wrap of low address
    step(1, 3'd2, 0, 12'hFFF, 8'h0, 0, 12'h0, "R5 jump to top");
    // R7, R8 nested call / return order
    step(1, 3'd4, 0, 12'h400, 8'h0, 0, 12'h0, "R7 call 1");
    step(1, 3'd4, 0, 12'h500, 8'h0, 0, 12'h0, "R7 call 2");
    step(1, 3'd4, 0, 12'h600, 8'h0, 0, 12'h0, "R7 call 3");
    step(1, 3'd5, 0, 12'h0, 8'h0, 0, 12'h0, "R8 return 3");
    step(1, 3'd5, 0, 12'h0, 8'h0, 0, 12'h0, "R8 return 2");
    step(1, 3'd5, 0, 12'h0, 8'h0, 0, 12'h0, "R8 return 1");
    // R11 boundary: 0x200 is allowed
    step(1, 3'd0, 0, 12'h0, 8'h0, 1, 12'h200, "R11 write at boundary");

    // random phase, kept free of faults
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] op;
      logic v;
      logic we;
      op = 3'($urandom % 8);
      if (op == 3'd4 && m_depth == 15) op = 3'd5;
      if (op == 3'd5 && m_depth == 0) op = 3'd4;
      v  = ($urandom % 5) != 0;
      we = ($urandom % 3) == 0;
      step(v, op, 1'($urandom), 12'($urandom), 8'($urandom), we,
           12'(12'h200 + ($urandom % 12'hE00)), v ? op_tag(op) : "R13 idle");
    end

    // R9: fill to the limit, then one more call
    do_reset();
    for (int n = 0; n < 15; n++)
      step(1, 3'd4, 0, 12'(12'h300 + n * 16), 8'h0, 0, 12'h0, "R7 fill call");
    step(1, 3'd4, 0, 12'hABC, 8'h0, 0, 12'h0, "R9 overflow call");
    step(1, 3'd5, 0, 12'h0, 8'h0, 0, 12'h0, "R12 return ignored after fault");
    step(1, 3'd2, 0, 12'h777, 8'h0, 0, 12'h0, "R12 jump ignored after fault");

    // R10: return with an empty stack
    do_reset();
    step(1, 3'd5, 0, 12'h0, 8'h0, 0, 12'h0, "R10 underflow return");
    step(1, 3'd0, 0, 12'h0, 8'h0, 0, 12'h0, "R12 advance ignored after fault");

    // R11: write just below the protected boundary
    do_reset();
    step(1, 3'd0, 0, 12'h0, 8'h0, 1, 12'h1FF, "R11 protected write");
    step(1, 3'd1, 1, 12'h0, 8'h0, 0, 12'h0, "R12 skip ignored after fault");
    step(0, 3'd0, 0, 12'h0, 8'h0, 0, 12'h0, "R12 flags sticky");

    do_reset();
    step(1, 3'd0, 0, 12'h0, 8'h0, 0, 12'h0, "R1 R3 advance after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule